// File: doc/BRIEF.md
# Key-Protected Clock Stop Controller

This block holds one 32-bit control word on a simple single-cycle peripheral bus. Software uses it to halt two clocks. One is the bus clock supplied from outside. The other is the internal local clock. Only two bits of the word are live. A write is accepted only when its top byte holds the unlock value 0xA5, so a stray write cannot freeze a clock by accident. A rejected write is reported by a one-cycle error pulse.

Each stop bit is carried into the domain of the clock it controls through a two-flop synchroniser. It then drives a latch-based gate that changes its enable only while that clock is low. A mode input tells the block where the bus clock comes from: a dedicated pin, or feedback from the system clock output. In feedback mode the local-clock stop bit also halts the feedback input clock.

The word survives a software reset. Only a power-on reset clears it.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_por is high the control word is cleared to 0x00000000 and all three gated clocks run; after power-on reset, reads return 0.
- R2: A write (sel=1, wr=1) whose wdata[31:24] equals 0xA5 loads wdata[1:0] into the control word at the next clk edge.
- R3: A write whose wdata[31:24] differs from 0xA5 leaves the control word unchanged and drives key_err high for exactly the one clk cycle after the write edge.
- R4: rst_sw does not change the control word; it clears key_err.
- R5: While sel=1 and wr=0, rdata shows bit 1 (bus-clock stop) and bit 0 (local-clock stop) of the control word, with rdata[31:2]=0; with sel=0, rdata is 0.
- R6: Bit 1 set holds ext_clk_o low and raises ext_stopped; bit 1 clear lets ext_clk_o follow ext_clk_i with ext_stopped low.
- R7: Bit 0 set holds loc_clk_o low and raises loc_stopped; bit 0 clear lets loc_clk_o run with loc_stopped low.
- R8: With fb_mode=1, bit 0 also holds fb_clk_o low and raises fb_stopped; with fb_mode=0, fb_clk_o runs whatever the control word holds.
- R9: A gated clock never emits a high pulse shorter than the high phase of its source clock.
- R10: A stop or restart reaches a gated clock output within four cycles of that clock after the clk edge that changes the controlling condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_sw | input | 1 | Software reset, synchronous, active high |
| sel | input | 1 | Bus access select |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data; top byte carries the key |
| rdata | output | 32 | Read data |
| key_err | output | 1 | One-cycle pulse after a write with a wrong key |
| fb_mode | input | 1 | 1 = bus clock fed back from the system clock output |
| ext_clk_i | input | 1 | Externally supplied bus clock |
| loc_clk_i | input | 1 | Local clock |
| fb_clk_i | input | 1 | Feedback input clock |
| ext_clk_o | output | 1 | Gated external bus clock |
| loc_clk_o | output | 1 | Gated local clock |
| fb_clk_o | output | 1 | Gated feedback clock |
| ext_stopped | output | 1 | External bus clock is held stopped |
| loc_stopped | output | 1 | Local clock is held stopped |
| fb_stopped | output | 1 | Feedback clock is held stopped |

## Verification
The bench sends key values one bit away from 0xA5 and fully random upper bytes. A design that compared only part of the byte would then let a locked write through and never raise key_err. Software resets are mixed between writes. A design that treated rst_sw like power-on reset would lose the stop bits, and the read-back and the gated clocks would both show it. Feedback mode is toggled with the local stop bit both set and clear. A design that wired the feedback gate to the wrong bit, or ignored the mode, would halt or free the wrong clock. Every high pulse of each gated clock is timed. A gate built without the low-phase latch would show a shortened pulse when stopping or restarting mid-phase.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    localparam int          REG_W       = 32;
    localparam int          KEY_W       = 8;
    localparam int          KEY_LSB     = REG_W - KEY_W;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;
    localparam int          NUM_DOM     = 3;
    localparam int          SYNC_STAGES = 2;

    // domain indices into the per-domain vectors
    localparam int DOM_EXT = 0;
    localparam int DOM_LOC = 1;
    localparam int DOM_FB  = 2;

    // packed order matches register bits: [1] bus stop, [0] local stop
    typedef struct packed {
        logic bus_stop;
        logic loc_stop;
    } stop_bits_t;

    localparam int CTRL_W = $bits(stop_bits_t);

    typedef enum logic {
        SRC_PIN      = 1'b0,
        SRC_FEEDBACK = 1'b1
    } bus_src_e;

    function automatic logic key_match(input logic [REG_W-1:0] d);
        return d[REG_W-1:KEY_LSB] == UNLOCK_KEY;
    endfunction

    // maps the control word and clock source to one stop request per domain
    function automatic logic [NUM_DOM-1:0] stop_map(input stop_bits_t s, input bus_src_e src);
        logic [NUM_DOM-1:0] r;
        r          = '0;
        r[DOM_EXT] = s.bus_stop;
        r[DOM_LOC] = s.loc_stop;
        r[DOM_FB]  = (src == SRC_FEEDBACK) && s.loc_stop;
        return r;
    endfunction

endpackage

// File: rtl/clkstop_regs.sv
`timescale 1ns/1ps
module clkstop_regs
    import clkstop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst_sw,
    input  logic             sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output stop_bits_t       stop_q,
    output logic             key_err
);

    logic wr_hit;
    logic wr_ok;

    assign wr_hit = sel && wr;
    assign wr_ok  = wr_hit && key_match(wdata);

    // control word: cleared by power-on reset only
    always_ff @(posedge clk) begin
        if (rst_por) begin
            stop_q <= '0;
        end else if (wr_ok) begin
            stop_q <= stop_bits_t'(wdata[CTRL_W-1:0]);
        end
    end

    // rejected-write flag, cleared by either reset
    always_ff @(posedge clk) begin
        if (rst_por || rst_sw) begin
            key_err <= 1'b0;
        end else begin
            key_err <= wr_hit && !wr_ok;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            rdata[CTRL_W-1:0] = stop_q;
        end
    end

endmodule

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk_in,
    input  logic rst,
    input  logic stop_req,
    output logic clk_out,
    output logic stopped
);

    logic stop_s;
    logic en_lat;

    clkstop_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk_in),
        .rst (rst),
        .d   (stop_req),
        .q   (stop_s)
    );

    // enable only moves while the source clock is low
    always_latch begin
        if (!clk_in) begin
            en_lat = rst || !stop_s;
        end
    end

    assign clk_out = clk_in && en_lat;
    assign stopped = !en_lat;

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_por,
    input  logic        rst_sw,
    input  logic        sel,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        key_err,
    input  logic        fb_mode,
    input  logic        ext_clk_i,
    input  logic        loc_clk_i,
    input  logic        fb_clk_i,
    output logic        ext_clk_o,
    output logic        loc_clk_o,
    output logic        fb_clk_o,
    output logic        ext_stopped,
    output logic        loc_stopped,
    output logic        fb_stopped
);

    stop_bits_t         stop_q;
    logic [NUM_DOM-1:0] stop_req;
    logic [NUM_DOM-1:0] src_clk;
    logic [NUM_DOM-1:0] gated_clk;
    logic [NUM_DOM-1:0] dom_stopped;

    clkstop_regs u_regs (
        .clk     (clk),
        .rst_por (rst_por),
        .rst_sw  (rst_sw),
        .sel     (sel),
        .wr      (wr),
        .wdata   (wdata),
        .rdata   (rdata),
        .stop_q  (stop_q),
        .key_err (key_err)
    );

    assign stop_req = stop_map(stop_q, bus_src_e'(fb_mode));

    assign src_clk[DOM_EXT] = ext_clk_i;
    assign src_clk[DOM_LOC] = loc_clk_i;
    assign src_clk[DOM_FB]  = fb_clk_i;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        clkstop_gate #(.STAGES(SYNC_STAGES)) u_gate (
            .clk_in   (src_clk[g]),
            .rst      (rst_por),
            .stop_req (stop_req[g]),
            .clk_out  (gated_clk[g]),
            .stopped  (dom_stopped[g])
        );
    end

    assign ext_clk_o   = gated_clk[DOM_EXT];
    assign loc_clk_o   = gated_clk[DOM_LOC];
    assign fb_clk_o    = gated_clk[DOM_FB];
    assign ext_stopped = dom_stopped[DOM_EXT];
    assign loc_stopped = dom_stopped[DOM_LOC];
    assign fb_stopped  = dom_stopped[DOM_FB];

endmodule

// File: rtl/clkstop_chk.sv
`timescale 1ns/1ps
module clkstop_chk (
    input logic        clk,
    input logic        rst_por,
    input logic        rst_sw,
    input logic        sel,
    input logic        wr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        key_err,
    input logic [1:0]  stop_q
);

    a_r1_por_clear: assert property (@(posedge clk)
        rst_por |=> (stop_q == 2'b00));

    a_r2_key_load: assert property (@(posedge clk) disable iff (rst_por)
        (sel && wr && wdata[31:24] == 8'hA5) |=> (stop_q == $past(wdata[1:0])));

    a_r3_bad_key_hold: assert property (@(posedge clk) disable iff (rst_por)
        (sel && wr && wdata[31:24] != 8'hA5) |=> ($stable(stop_q) && key_err));

    a_r3_err_source: assert property (@(posedge clk) disable iff (rst_por)
        key_err |-> $past(sel && wr && !rst_sw));

    a_r4_sw_keep: assert property (@(posedge clk) disable iff (rst_por)
        (rst_sw && !(sel && wr)) |=> ($stable(stop_q) && !key_err));

    a_r5_read_upper_zero: assert property (@(posedge clk) disable iff (rst_por)
        (sel && !wr) |-> (rdata[31:2] == 30'd0 && rdata[1:0] == stop_q));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst_por)
        !sel |-> (rdata == 32'd0));

endmodule

bind clkstop_ctrl clkstop_chk u_chk (
    .clk     (clk),
    .rst_por (rst_por),
    .rst_sw  (rst_sw),
    .sel     (sel),
    .wr      (wr),
    .wdata   (wdata),
    .rdata   (rdata),
    .key_err (key_err),
    .stop_q  (stop_q)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb;

    localparam real CLK_HALF = 4.0;   // 125 MHz
    localparam real EXT_HALF = 15.0;
    localparam real LOC_HALF = 5.0;
    localparam real FB_HALF  = 6.0;

    logic        clk = 0, rst_por = 1, rst_sw = 0, sel = 0, wr = 0, fb_mode = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        key_err;
    logic        ext_clk_i = 0, loc_clk_i = 0, fb_clk_i = 0;
    logic        ext_clk_o, loc_clk_o, fb_clk_o;
    logic        ext_stopped, loc_stopped, fb_stopped;

    int n_chk = 0, n_fail = 0;
    int ext_cnt = 0, loc_cnt = 0, fb_cnt = 0;
    int runt_cnt = 0, pulse_cnt = 0;
    bit done = 0;
    logic [1:0] mdl = 2'b00;

    always #(CLK_HALF) clk = ~clk;
    always #(EXT_HALF) ext_clk_i = ~ext_clk_i;
    always #(LOC_HALF) loc_clk_i = ~loc_clk_i;
    always #(FB_HALF)  fb_clk_i  = ~fb_clk_i;

    clkstop_ctrl u_dut (
        .clk(clk), .rst_por(rst_por), .rst_sw(rst_sw), .sel(sel), .wr(wr),
        .wdata(wdata), .rdata(rdata), .key_err(key_err), .fb_mode(fb_mode),
        .ext_clk_i(ext_clk_i), .loc_clk_i(loc_clk_i), .fb_clk_i(fb_clk_i),
        .ext_clk_o(ext_clk_o), .loc_clk_o(loc_clk_o), .fb_clk_o(fb_clk_o),
        .ext_stopped(ext_stopped), .loc_stopped(loc_stopped), .fb_stopped(fb_stopped)
    );

    // edge counters and high-pulse width monitors (R9)
    realtime ext_rise, loc_rise, fb_rise;
    bit ext_seen = 0, loc_seen = 0, fb_seen = 0;
    always @(posedge ext_clk_o) begin ext_cnt++; ext_rise = $realtime; ext_seen = 1; end
    always @(posedge loc_clk_o) begin loc_cnt++; loc_rise = $realtime; loc_seen = 1; end
    always @(posedge fb_clk_o)  begin fb_cnt++;  fb_rise  = $realtime; fb_seen  = 1; end
    always @(negedge ext_clk_o) if (ext_seen) begin pulse_cnt++; if ($realtime - ext_rise < EXT_HALF - 0.01) runt_cnt++; end
    always @(negedge loc_clk_o) if (loc_seen) begin pulse_cnt++; if ($realtime - loc_rise < LOC_HALF - 0.01) runt_cnt++; end
    always @(negedge fb_clk_o)  if (fb_seen)  begin pulse_cnt++; if ($realtime - fb_rise  < FB_HALF  - 0.01) runt_cnt++; end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] model_write(input logic [1:0] cur, input logic [31:0] d);
        return (d[31:24] == 8'hA5) ? d[1:0] : cur;
    endfunction

    function automatic logic [2:0] model_stops(input logic [1:0] w, input logic fb);
        return {fb & w[0], w[0], w[1]};   // {fb, loc, ext}
    endfunction

    task automatic bus_write(input logic [31:0] d);
        logic exp_err;
        exp_err = (d[31:24] != 8'hA5);
        @(negedge clk); sel = 1; wr = 1; wdata = d;
        @(negedge clk); sel = 0; wr = 0; wdata = '0;
        mdl = model_write(mdl, d);
        check(key_err == exp_err, "R3", "key_err after write", key_err, exp_err);
        @(negedge clk);
        check(key_err == 1'b0, "R3", "key_err one cycle only", key_err, 0);
    endtask

    task automatic bus_read_check(input string req);
        @(negedge clk); sel = 1; wr = 0;
        #1;
        check(rdata == {30'd0, mdl}, req, "read data", rdata, {30'd0, mdl});
        @(negedge clk); sel = 0;
        #1;
        check(rdata == 32'd0, "R5", "rdata idle", rdata, 0);
    endtask

    task automatic clocks_check(input string req);
        logic [2:0] st;
        st = model_stops(mdl, fb_mode);
        // settle: R10 allows four source cycles, slowest is 30 ns
        repeat (20) @(negedge clk);
        ext_cnt = 0; loc_cnt = 0; fb_cnt = 0;
        repeat (25) @(negedge clk);
        check((ext_cnt == 0) == st[0] && ext_stopped == st[0], "R6", {req, " ext clock"}, ext_cnt, st[0]);
        check((loc_cnt == 0) == st[1] && loc_stopped == st[1], "R7", {req, " local clock"}, loc_cnt, st[1]);
        check((fb_cnt == 0) == st[2] && fb_stopped == st[2], "R8", {req, " fb clock"}, fb_cnt, st[2]);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (8) @(negedge clk);
        rst_por = 0;
        // R1: reset state
        @(negedge clk); #1;
        check(rdata == 0, "R1", "rdata idle after POR", rdata, 0);
        bus_read_check("R1");
        clocks_check("R1 after POR");

        // R2 directed loads, R10 timing covered by settle window
        bus_write(32'hA500_0002); bus_read_check("R2"); clocks_check("R2 bus stop");
        bus_write(32'hA5FF_FFFD); bus_read_check("R2"); clocks_check("R2 local stop");
        fb_mode = 1; clocks_check("R8 feedback stop");
        fb_mode = 0; clocks_check("R8 pin mode");

        // R3 near-miss keys
        bus_write(32'hA400_0000); bus_read_check("R3");
        bus_write(32'h2500_0000); bus_read_check("R3");
        bus_write(32'hA700_0000); bus_read_check("R3");
        clocks_check("R3 after rejects");

        // R4 software reset right after a rejected write
        @(negedge clk); sel = 1; wr = 1; wdata = 32'h5A00_0000;
        @(negedge clk); sel = 0; wr = 0; rst_sw = 1;
        @(negedge clk); rst_sw = 0; #1;
        check(key_err == 0, "R4", "key_err cleared by rst_sw", key_err, 0);
        bus_read_check("R4");

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom % 2) d[31:24] = 8'hA5;
            fb_mode = $urandom % 2;
            bus_write(d);
            if ($urandom % 4 == 0) begin
                @(negedge clk); rst_sw = 1;
                @(negedge clk); rst_sw = 0;
            end
            bus_read_check("R2");
            clocks_check("random");
        end

        // R1 power-on reset clears a set word
        bus_write(32'hA500_0003);
        fb_mode = 1;
        @(negedge clk); rst_por = 1;
        repeat (3) @(negedge clk); rst_por = 0;
        mdl = 2'b00;
        bus_read_check("R1");
        clocks_check("R1 POR restart");

        check(runt_cnt == 0 && pulse_cnt > 0, "R9", "short pulses", runt_cnt, 0);
        done = 1;
        finish_run();
    end

    initial begin
        #1_000_000;
        if (!done) begin
            check(1'b0, "WDOG", "watchdog expired", 0, 1);
            finish_run();
        end
    end

endmodule